// File: doc/BRIEF.md
# Reciprocal Period-Averaging Frequency Meter

This block measures the frequency of a slow-to-moderate digital signal by counting cycles of a fixed, crystal-derived reference clock across a whole number of input periods. The measurement window opens on one rising edge of the input and closes on a later rising edge, so the count spans complete input periods. Resolution is therefore set in reference counts, not by a fixed time window. Downstream logic or software divides: frequency = periods × reference frequency / count.

The asynchronous input passes through a two-flop synchronizer, and its rising edges are found in the reference clock domain. An optional prescaler divides the rising-edge stream, which keeps the event rate low at high input frequencies. A programmable number N of prescaled periods forms the window. With a 1 MHz reference, an input range of 7 Hz to 100 kHz and a target of one part in 50000, the window must hold more than 5000 periods at the top of the range. One period at the bottom of the range already gives about 143000 counts, so the count register is 32 bits by default.

A control state machine steps through the states IDLE, ARMED, COUNTING and DONE. Its transitions are:
- start: IDLE to ARMED, on a start request.
- open: ARMED to COUNTING, on the first prescaled event.
- close: COUNTING to DONE, on the N-th event after opening.
- retire: DONE to IDLE, always after one cycle.
- abort: ARMED or COUNTING to IDLE, when the quiet timer expires.

Top module: `recip_freq_meter`

## Requirements
- R1: While reset is asserted and right after it, ref_count, period_count, done, busy, overflow and no_signal are all 0.
- R2: A start pulse seen while idle moves the block to ARMED, so busy is 1 from the next cycle. The same edge clears overflow and no_signal.
- R3: The window opens on the first prescaled rising event after arming. ref_count is the number of reference clock edges from the opening event to the closing event. For a steady input with P reference cycles per prescaled period, this equals N×P.
- R4: The window closes on the N-th prescaled event after it opens. An n_periods value of 0 is treated as 1. period_count is the number of raw synchronized rising edges inside the window, with the opening edge excluded and the closing edge included. For a steady input this equals N×D.
- R5: The prescale divisor D is presc_div, and values 0 and 1 both mean no division. The prescaler is cleared while idle, so events fall on raw rising edges number D, 2D, 3D and so on after arming.
- R6: done is high for exactly one cycle: the cycle after the closing event. ref_count and period_count take their new values in that same cycle and do not change at any other time.
- R7: The input is sampled by two synchronizer flops plus one edge-history flop. A rising edge therefore acts on the third clock edge after it is first sampled.
- R8: The reference counter saturates at its maximum value. If a window exceeds that value, ref_count reports the maximum and the sticky overflow flag is set. The flag stays set until the next accepted start.
- R9: If timeout_cycles is nonzero and that many consecutive clock edges pass in ARMED or COUNTING with no prescaled event, the block returns to IDLE with no_signal set. In that case done does not pulse and the results do not change. A timeout_cycles value of 0 disables the timer.
- R10: A start pulse while ARMED, COUNTING or DONE is ignored. The running measurement finishes with the same result it would have had without the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference counting clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Asynchronous signal under measurement |
| start | input | 1 | Measurement request, honoured only while idle |
| n_periods | input | PER_W | Prescaled periods per window (0 acts as 1) |
| presc_div | input | PS_W | Prescale divisor (0 and 1 mean none) |
| timeout_cycles | input | TO_W | Quiet-time limit in reference cycles (0 disables) |
| ref_count | output | CNT_W | Latched reference count of the last window |
| period_count | output | PER_W+PS_W | Latched raw input periods of the last window |
| done | output | 1 | One-cycle result-valid pulse |
| busy | output | 1 | High in ARMED, COUNTING and DONE |
| overflow | output | 1 | Sticky flag: the reference count saturated |
| no_signal | output | 1 | Sticky flag: the last run timed out |

## Verification
The main measurement is run with steady square waves of several periods. These cases cover prescaler divisors of 1, 5 and 0, and n_periods values of 4, 3 and 0. Together they separate an off-by-one in the window edges (count N×P against (N±1)×P) from a wrong prescale phase (count N×D). A long slow input with a narrowed counter shows saturation against wrap-around. A silent input, an input that stops mid-window, and a silent input with the timer disabled separate the abort path from a stuck or early-aborting machine. A second start pulse in mid-window shows that the request is ignored and does not restart the window. A behavioural reference model compares every output on every clock, so each latency shift is caught.

// File: rtl/freqc_pkg.sv
package freqc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2,
        ST_DONE  = 2'd3
    } meas_state_e;
endpackage

// File: rtl/freqc_sync_edge.sv
module freqc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    // STAGES synchronizer flops followed by one history flop for edge detection
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], async_in};
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/freqc_prescaler.sv
module freqc_prescaler #(
    parameter int PS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            rise,
    input  logic [PS_W-1:0] div,
    output logic            tick
);
    logic [PS_W-1:0] cnt;
    logic [PS_W-1:0] div_eff;

    assign div_eff = (div == '0) ? {{(PS_W-1){1'b0}}, 1'b1} : div;
    assign tick    = rise && (cnt == div_eff - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (rise)       cnt <= tick ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/freqc_quiet_timer.sv
module freqc_quiet_timer #(
    parameter int TO_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            run,
    input  logic [TO_W-1:0] limit,
    output logic            expire
);
    logic [TO_W-1:0] cnt;

    assign expire = run && !restart && (limit != '0) && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (restart) cnt <= '0;
        else if (run)     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/recip_freq_meter.sv
module recip_freq_meter
    import freqc_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PER_W       = 32,
    parameter int PS_W        = 16,
    parameter int TO_W        = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sig_in,
    input  logic                  start,
    input  logic [PER_W-1:0]      n_periods,
    input  logic [PS_W-1:0]       presc_div,
    input  logic [TO_W-1:0]       timeout_cycles,
    output logic [CNT_W-1:0]      ref_count,
    output logic [PER_W+PS_W-1:0] period_count,
    output logic                  done,
    output logic                  busy,
    output logic                  overflow,
    output logic                  no_signal
);
    localparam int PCW = PER_W + PS_W;

    meas_state_e state, nxt;

    logic             rise, ev, quiet_exp, last_ev, accept;
    logic [PER_W-1:0] n_eff;
    logic [PER_W-1:0] ev_cnt;
    logic [CNT_W-1:0] refcnt, ref_next;
    logic [PCW-1:0]   raw_cnt;
    logic [CNT_W-1:0] res_ref;
    logic [PCW-1:0]   res_per;
    logic             ovf_q, nosig_q;

    freqc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sig_in), .rise(rise)
    );

    freqc_prescaler #(.PS_W(PS_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .clear(state == ST_IDLE),
        .rise(rise), .div(presc_div), .tick(ev)
    );

    freqc_quiet_timer #(.TO_W(TO_W)) u_quiet (
        .clk(clk), .rst_n(rst_n),
        .restart(ev || accept),
        .run((state == ST_ARMED) || (state == ST_COUNT)),
        .limit(timeout_cycles), .expire(quiet_exp)
    );

    assign accept   = (state == ST_IDLE) && start;
    assign n_eff    = (n_periods == '0) ? {{(PER_W-1){1'b0}}, 1'b1} : n_periods;
    assign last_ev  = ev && (ev_cnt == n_eff - 1'b1);
    assign ref_next = (&refcnt) ? refcnt : refcnt + 1'b1;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_ARMED;
            ST_ARMED: begin
                if (ev)             nxt = ST_COUNT;
                else if (quiet_exp) nxt = ST_IDLE;
            end
            ST_COUNT: begin
                if (last_ev)        nxt = ST_DONE;
                else if (quiet_exp) nxt = ST_IDLE;
            end
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refcnt  <= '0;
            raw_cnt <= '0;
            ev_cnt  <= '0;
            res_ref <= '0;
            res_per <= '0;
            ovf_q   <= 1'b0;
            nosig_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        ovf_q   <= 1'b0;
                        nosig_q <= 1'b0;
                    end
                end
                ST_ARMED: begin
                    if (ev) begin
                        refcnt  <= '0;
                        raw_cnt <= '0;
                        ev_cnt  <= '0;
                    end else if (quiet_exp) begin
                        nosig_q <= 1'b1;
                    end
                end
                ST_COUNT: begin
                    refcnt <= ref_next;
                    if (&refcnt) ovf_q <= 1'b1;
                    if (rise) raw_cnt <= raw_cnt + 1'b1;
                    if (ev) ev_cnt <= ev_cnt + 1'b1;
                    if (last_ev) begin
                        res_ref <= ref_next;
                        res_per <= raw_cnt + 1'b1;
                    end else if (!ev && quiet_exp) begin
                        nosig_q <= 1'b1;
                    end
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    assign done         = (state == ST_DONE);
    assign busy         = (state != ST_IDLE);
    assign ref_count    = res_ref;
    assign period_count = res_per;
    assign overflow     = ovf_q;
    assign no_signal    = nosig_q;
endmodule

// File: rtl/freqc_checker.sv
module freqc_checker #(
    parameter int CNT_W = 32,
    parameter int PCW   = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             overflow,
    input logic             no_signal,
    input logic [CNT_W-1:0] ref_count,
    input logic [PCW-1:0]   period_count
);
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_results_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> ($stable(ref_count) && $stable(period_count)) || done);

    p_start_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !overflow && !no_signal));

    p_nosig_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(no_signal) |-> !busy);

    p_done_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && !no_signal));

    p_overflow_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !(start && !busy)) |=> overflow);
endmodule

bind recip_freq_meter freqc_checker #(.CNT_W(CNT_W), .PCW(PER_W + PS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .overflow(overflow), .no_signal(no_signal),
    .ref_count(ref_count), .period_count(period_count)
);

// File: tb/sim_recip_freq_meter.sv
`timescale 1ns/1ps
module sim_recip_freq_meter;
    localparam int CW = 12;
    localparam longint MAXC = (1 << CW) - 1;

    logic        clk = 0, rst_n = 0, sig_in = 0, start = 0;
    logic [31:0] n_periods = 0, timeout_cycles = 0;
    logic [15:0] presc_div = 0;
    logic [CW-1:0] ref_count;
    logic [47:0] period_count;
    logic done, busy, overflow, no_signal;

    int n_chk = 0, n_fail = 0;
    bit fin = 0;
    bit sig_en = 0;
    int sig_per = 400;

    recip_freq_meter #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .start(start),
        .n_periods(n_periods), .presc_div(presc_div), .timeout_cycles(timeout_cycles),
        .ref_count(ref_count), .period_count(period_count), .done(done), .busy(busy),
        .overflow(overflow), .no_signal(no_signal)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // input generator, edges kept away from clock edges
    initial begin
        #3;
        forever begin
            if (sig_en) begin
                sig_in = 1; #(sig_per/2);
                sig_in = 0; #(sig_per - sig_per/2);
            end else begin
                sig_in = 0; #20;
            end
        end
    end

    // behavioural reference model
    int ms;              // 0 idle, 1 armed, 2 counting, 3 done
    bit hist[$];
    longint mcnt, mraw, mres_ref, mres_per;
    int mevs, mquiet, mpc;
    bit mov, mns;

    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; hist = '{0, 0, 0}; mcnt = 0; mraw = 0; mres_ref = 0; mres_per = 0;
            mevs = 0; mquiet = 0; mpc = 0; mov = 0; mns = 0;
        end else begin
            bit r, e;
            longint neff, deff;
            neff = (n_periods == 0) ? 1 : n_periods;
            deff = (presc_div == 0) ? 1 : presc_div;
            r = hist[1] && !hist[2];
            hist.push_front(sig_in);
            void'(hist.pop_back());
            e = 0;
            if (ms == 0) mpc = 0;
            else if (r) begin
                mpc++;
                if (mpc == deff) begin e = 1; mpc = 0; end
            end
            case (ms)
                0: if (start) begin ms = 1; mov = 0; mns = 0; mquiet = 0; end
                1: begin
                    if (e) begin ms = 2; mcnt = 0; mraw = 0; mevs = 0; mquiet = 0; end
                    else begin
                        mquiet++;
                        if (timeout_cycles != 0 && mquiet == timeout_cycles) begin ms = 0; mns = 1; end
                    end
                end
                2: begin
                    mcnt++;
                    if (mcnt > MAXC) mov = 1;
                    if (r) mraw++;
                    if (e) begin
                        mevs++; mquiet = 0;
                        if (mevs == neff) begin
                            mres_ref = (mcnt > MAXC) ? MAXC : mcnt;
                            mres_per = mraw;
                            ms = 3;
                        end
                    end else begin
                        mquiet++;
                        if (timeout_cycles != 0 && mquiet == timeout_cycles) begin ms = 0; mns = 1; end
                    end
                end
                default: ms = 0;
            endcase
        end
    end

    // compare every clock
    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk(done == (ms == 3), "R6 done vs model", done, ms == 3);
            chk(busy == (ms != 0), "R2 busy vs model", busy, ms != 0);
            chk(ref_count == mres_ref, "R3 ref_count vs model", ref_count, mres_ref);
            chk(period_count == mres_per, "R4 period_count vs model", period_count, mres_per);
            chk(overflow == mov, "R8 overflow vs model", overflow, mov);
            chk(no_signal == mns, "R9 no_signal vs model", no_signal, mns);
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int n, input int d, input int t, input int per,
                           input longint exp_ref, input longint exp_per, input string tag);
        bit seen;
        n_periods = n; presc_div = d; timeout_cycles = t; sig_per = per; sig_en = 1;
        pulse_start();
        seen = 0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        chk(seen, {tag, " done seen"}, seen, 1);
        chk(ref_count == exp_ref, {tag, " ref_count"}, ref_count, exp_ref);
        chk(period_count == exp_per, {tag, " period_count"}, period_count, exp_per);
        @(negedge clk);
        chk(!done, "R6 done lasts one cycle", done, 0);
    endtask

    initial begin
        #4_000_000;
        if (!fin) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            fin = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        wait_cycles(3);
        chk(ref_count == 0 && period_count == 0 && !done && !busy && !overflow && !no_signal,
            "R1 reset state", {done, busy, overflow, no_signal}, 0);
        @(negedge clk) rst_n = 1;
        @(negedge clk);
        chk(!busy && ref_count == 0, "R1 idle after reset", busy, 0);

        // R3 R4 R7: plain window, P=20 N=4
        measure(4, 1, 1000, 400, 80, 4, "R3 N4 P20");
        // R5: divide by 5, P raw 10
        measure(3, 5, 1000, 200, 150, 15, "R5 div5");
        // R4 R5: zeros act as one
        measure(0, 0, 1000, 600, 30, 1, "R4 n0 d0");
        // R8: saturation, 30*200 > 4095
        measure(30, 1, 1000, 4000, MAXC, 30, "R8 saturate");
        chk(overflow, "R8 overflow set", overflow, 1);
        wait_cycles(5);
        chk(overflow, "R8 overflow sticky", overflow, 1);
        // R2: new start clears the flag
        n_periods = 4; presc_div = 1; sig_per = 400;
        pulse_start();
        chk(!overflow && busy, "R2 start clears overflow", overflow, 0);
        wait_cycles(150);
        // R10: second start mid-window ignored
        n_periods = 6; presc_div = 1; timeout_cycles = 1000; sig_per = 400;
        pulse_start();
        wait_cycles(40);
        pulse_start();
        begin
            bit seen = 0;
            for (int i = 0; i < 2000 && !seen; i++) begin
                @(negedge clk);
                if (done) seen = 1;
            end
            chk(seen && ref_count == 120, "R10 restart ignored", ref_count, 120);
        end
        wait_cycles(3);
        // R9: silent input
        sig_en = 0; timeout_cycles = 50;
        pulse_start();
        wait_cycles(70);
        chk(no_signal && !busy, "R9 timeout when armed", no_signal, 1);
        chk(ref_count == 120, "R9 results unchanged", ref_count, 120);
        // R9: input stops mid-window
        sig_en = 1; n_periods = 100; sig_per = 400;
        pulse_start();
        chk(!no_signal, "R2 start clears no_signal", no_signal, 0);
        wait_cycles(100);
        sig_en = 0;
        wait_cycles(120);
        chk(no_signal && !busy, "R9 timeout while counting", no_signal, 1);
        // R9: timer disabled
        timeout_cycles = 0;
        pulse_start();
        wait_cycles(300);
        chk(busy && !no_signal, "R9 disabled timer keeps waiting", busy, 1);
        n_periods = 2; sig_per = 400; sig_en = 1;
        begin
            bit seen = 0;
            for (int i = 0; i < 2000 && !seen; i++) begin
                @(negedge clk);
                if (done) seen = 1;
            end
            chk(seen && ref_count == 40, "R3 result after late signal", ref_count, 40);
        end
        wait_cycles(5);
        fin = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule